// File: doc/BRIEF.md
# Guarded Calendar Time Loader

This block stands between an 8-bit processor bus and a calendar time core. It lets software set the time without the risk of a half-written value, and read the time without the risk of a torn value. To change the time, software first writes an unlock key. While the block is unlocked, software stores new values for any of the six BCD fields (second, minute, hour, day, month, year) into shadow registers. Writing any other value to the key register locks the block again. On that event the shadow contents are checked. If they are legal, they are handed to the core in a single one-cycle load.

Any shadow field that software did not write keeps the all-ones marker that it receives when the block is unlocked. For such fields the core's running value is used instead. If the load would coincide with a one-second carry from the core, the carry goes first and the load waits. Reading the seconds register takes a snapshot of the core time, and the other field reads are served from that snapshot. Writes and reads use the same field addresses. A write to a field while the block is locked, or a load holding an illegal time, sets a sticky error bit that drives the interrupt.

Top module: `rtc_set_shadow_if`

## Requirements
- R1: After reset, unlock_o, err_irq_o, commit_o and snap_o are 0 and rdata_o is 0x00.
- R2: Writing KEY (default 0xA5) to address 0x08 sets unlock_o from the next cycle. Writing any other value to 0x08 clears it.
- R3: A write to a field address (0x00 second, 0x01 minute, 0x02 hour, 0x03 day, 0x04 month, 0x05 year) while unlock_o is 0 sets the error bit and does not alter any shadow field.
- R4: When unlock_o rises, every shadow field becomes 0xFF. A field that still holds 0xFF when the load is issued takes the matching byte of cur_time_i. Bytes of cur_time_i and commit_time_o are packed with the second in bits 7:0 and the year in bits 47:40.
- R5: In the cycle after the relocking write, commit_o is high for exactly one cycle with the merged fields on commit_time_o, provided that carry_i is low and the merged time is legal.
- R6: While carry_i is high, a pending load is held off. It is issued in the first cycle in which carry_i is low.
- R7: A merged time is legal only if all of the following hold: every BCD digit is at most 9; second and minute are at most 59; hour is at most 23; month is 1 to 12; day is 1 to the month length. An illegal load produces no commit_o and sets the error bit.
- R8: February has 29 days when the two-digit year is a multiple of 4 (year 00 included), and 28 days otherwise.
- R9: A read of address 0x00 pulses snap_o and latches all six fields of cur_time_i. Reads of 0x01 to 0x05 return the latched values, even if cur_time_i has changed since.
- R10: Read data appears on rdata_o in the cycle after the read strobe. Address 0x09 returns the error bit in bit 0 and unlock_o in bit 1. Unmapped addresses return 0.
- R11: The error bit drives err_irq_o and stays set until a write to 0x09 with bit 0 = 1. If an error event and such a clear occur in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Bus address |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered bus read data |
| carry_i | input | 1 | One-second carry from the time core |
| cur_time_i | input | 48 | Running BCD time from the core |
| snap_o | output | 1 | Snapshot request to the core |
| commit_o | output | 1 | Parallel load strobe to the core |
| commit_time_o | output | 48 | Merged BCD time to load |
| unlock_o | output | 1 | Write protection lifted |
| err_irq_o | output | 1 | Sticky error interrupt |

## Verification
The hardest situation to reach from the ports is a pending load that meets a carry. A second hard case is an error that is raised in the same cycle that software clears the bit. The bench holds carry_i high across the relocking write for a random number of cycles and then drops it. It also drops carry_i on the very cycle of a status clear write, so that an illegal load fires together with the clear. Random rounds write random subsets of fields over a random legal running time, and sometimes write raw bytes. This produces day and month mixes between shadow and core values that are only legal or illegal after merging.

// File: rtl/rtc_set_pkg.sv
package rtc_set_pkg;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int TW = NF * FW;

  function automatic logic [6:0] bcd_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [6:0] days_in(input logic [6:0] mon, input logic leap);
    case (mon)
      7'd2:                    return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:                 return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_set_shadow.sv
module rtc_set_shadow
  import rtc_set_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_ones_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [FW-1:0] wdata_i,
  input  logic [TW-1:0] cur_i,
  output logic [TW-1:0] merged_o
);
  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [FW-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              sh_q <= '1;
      else if (load_ones_i)                     sh_q <= '1;
      else if (wr_en_i && wr_sel_i == 3'(i))    sh_q <= wdata_i;
    end
    // all-ones marks an untouched field: keep the running value
    assign merged_o[i*FW +: FW] = (sh_q == '1) ? cur_i[i*FW +: FW] : sh_q;
  end
endmodule

// File: rtl/rtc_set_legal.sv
module rtc_set_legal
  import rtc_set_pkg::*;
(
  input  logic [TW-1:0] t_i,
  output logic          ok_o
);
  logic [NF-1:0] dig_ok;
  for (genvar i = 0; i < NF; i++) begin : g_dig
    assign dig_ok[i] = (t_i[i*FW+4 +: 4] <= 4'd9) && (t_i[i*FW +: 4] <= 4'd9);
  end

  logic [6:0] sec, mnt, hr, day, mon, yr;
  logic       leap;
  always_comb begin
    sec  = bcd_bin(t_i[0*FW +: FW]);
    mnt  = bcd_bin(t_i[1*FW +: FW]);
    hr   = bcd_bin(t_i[2*FW +: FW]);
    day  = bcd_bin(t_i[3*FW +: FW]);
    mon  = bcd_bin(t_i[4*FW +: FW]);
    yr   = bcd_bin(t_i[5*FW +: FW]);
    leap = (yr[1:0] == 2'b00);
    ok_o = (&dig_ok) && (sec <= 7'd59) && (mnt <= 7'd59) && (hr <= 7'd23) &&
           (mon >= 7'd1) && (mon <= 7'd12) &&
           (day >= 7'd1) && (day <= days_in(mon, leap));
  end
endmodule

// File: rtl/rtc_set_rcache.sv
module rtc_set_rcache
  import rtc_set_pkg::*;
#(
  parameter logic [7:0] ADDR_STAT = 8'h09
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [7:0]    rd_addr_i,
  input  logic [TW-1:0] cur_i,
  input  logic [7:0]    stat_i,
  output logic [7:0]    rdata_o
);
  logic [TW-1:0] cache_q;
  logic          snap;
  assign snap = rd_en_i && (rd_addr_i == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cache_q <= '0;
    else if (snap) cache_q <= cur_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      if (snap)                         rdata_o <= cur_i[FW-1:0];
      else if (rd_addr_i < 8'(NF))      rdata_o <= cache_q[rd_addr_i[2:0]*FW +: FW];
      else if (rd_addr_i == ADDR_STAT)  rdata_o <= stat_i;
      else                              rdata_o <= '0;
    end
  end
endmodule

// File: rtl/rtc_set_shadow_if.sv
module rtc_set_shadow_if
  import rtc_set_pkg::*;
#(
  parameter logic [7:0] KEY       = 8'hA5,
  parameter logic [7:0] ADDR_KEY  = 8'h08,
  parameter logic [7:0] ADDR_STAT = 8'h09
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          carry_i,
  input  logic [TW-1:0] cur_time_i,
  output logic          snap_o,
  output logic          commit_o,
  output logic [TW-1:0] commit_time_o,
  output logic          unlock_o,
  output logic          err_irq_o
);
  logic wr, rd, field_hit, key_wr, key_ok, stat_wr;
  logic unlock_q, pend_q, err_q, legal, fire, load_ones, relock;
  logic [TW-1:0] merged;

  assign wr        = !wr_ni;
  assign rd        = !rd_ni;
  assign field_hit = addr_i < 8'(NF);
  assign key_wr    = wr && (addr_i == ADDR_KEY);
  assign key_ok    = (wdata_i == KEY);
  assign stat_wr   = wr && (addr_i == ADDR_STAT);
  assign load_ones = key_wr && key_ok && !unlock_q;
  assign relock    = key_wr && !key_ok && unlock_q;
  assign fire      = pend_q && !carry_i;  // carry has priority over the load

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (key_wr) unlock_q <= key_ok;
      if (relock)    pend_q <= 1'b1;
      else if (fire) pend_q <= 1'b0;
      if ((wr && field_hit && !unlock_q) || (fire && !legal)) err_q <= 1'b1;
      else if (stat_wr && wdata_i[0])                         err_q <= 1'b0;
    end
  end

  rtc_set_shadow u_shadow (
    .clk_i, .rst_ni,
    .load_ones_i (load_ones),
    .wr_en_i     (wr && field_hit && unlock_q),
    .wr_sel_i    (addr_i[2:0]),
    .wdata_i,
    .cur_i       (cur_time_i),
    .merged_o    (merged)
  );

  rtc_set_legal u_legal (.t_i(merged), .ok_o(legal));

  rtc_set_rcache #(.ADDR_STAT(ADDR_STAT)) u_rcache (
    .clk_i, .rst_ni,
    .rd_en_i   (rd),
    .rd_addr_i (addr_i),
    .cur_i     (cur_time_i),
    .stat_i    ({6'b0, unlock_q, err_q}),
    .rdata_o
  );

  assign snap_o        = rd && (addr_i == 8'h00);
  assign commit_o      = fire && legal;
  assign commit_time_o = merged;
  assign unlock_o      = unlock_q;
  assign err_irq_o     = err_q;
endmodule

// File: rtl/rtc_set_sva.sv
module rtc_set_sva #(
  parameter logic [7:0] KEY       = 8'hA5,
  parameter logic [7:0] ADDR_KEY  = 8'h08,
  parameter logic [7:0] ADDR_STAT = 8'h09
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       wr_ni,
  input logic [7:0] wdata_i,
  input logic       carry_i,
  input logic       commit_o,
  input logic       unlock_o,
  input logic       err_irq_o
);
  AST_PROT_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && addr_i < 8'd6 && !unlock_o) |=> err_irq_o); // R3
  AST_UNLOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && addr_i == ADDR_KEY && wdata_i == KEY) |=> unlock_o); // R2
  AST_COMMIT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !unlock_o); // R5
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R5
  AST_CARRY_DEFERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i |-> !commit_o); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o && !(!wr_ni && addr_i == ADDR_STAT && wdata_i[0])) |=> err_irq_o); // R11
endmodule

bind rtc_set_shadow_if rtc_set_sva #(.KEY(KEY), .ADDR_KEY(ADDR_KEY), .ADDR_STAT(ADDR_STAT)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_ni(wr_ni), .wdata_i(wdata_i),
  .carry_i(carry_i), .commit_o(commit_o), .unlock_o(unlock_o), .err_irq_o(err_irq_o)
);

// File: tb/sim_rtc_set_shadow_if.sv
module sim_rtc_set_shadow_if;
  localparam int CLK_P = 10;
  localparam logic [7:0] KEY = 8'hA5, A_KEY = 8'h08, A_STAT = 8'h09;

  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic wr_n = 1, rd_n = 1, carry = 0;
  logic [47:0] cur = 0;
  logic [7:0] rdata;
  logic snap, commit, unlock, err_irq;
  logic [47:0] ctime;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_set_shadow_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_ni(wr_n), .rd_ni(rd_n),
    .wdata_i(wdata), .rdata_o(rdata), .carry_i(carry), .cur_time_i(cur),
    .snap_o(snap), .commit_o(commit), .commit_time_o(ctime),
    .unlock_o(unlock), .err_irq_o(err_irq));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit tb_legal(input logic [47:0] t);
    int v[6];
    for (int i = 0; i < 6; i++) begin
      if (t[i*8+4 +: 4] > 9 || t[i*8 +: 4] > 9) return 0;
      v[i] = int'(t[i*8+4 +: 4]) * 10 + int'(t[i*8 +: 4]);
    end
    if (v[0] > 59 || v[1] > 59 || v[2] > 23) return 0;
    if (v[4] < 1 || v[4] > 12) return 0;
    return v[3] >= 1 && v[3] <= dim(v[4], v[5]);
  endfunction

  function automatic logic [47:0] gen_time();
    int y = $urandom % 100, mo = 1 + $urandom % 12;
    int d = 1 + $urandom % dim(mo, y);
    return {to_bcd(y), to_bcd(mo), to_bcd(d), to_bcd($urandom % 24),
            to_bcd($urandom % 60), to_bcd($urandom % 60)};
  endfunction

  function automatic logic [47:0] mk(input int y, mo, d, h, mi, s);
    return {to_bcd(y), to_bcd(mo), to_bcd(d), to_bcd(h), to_bcd(mi), to_bcd(s)};
  endfunction

  // inputs driven at negedge; returns at the negedge after the sampling edge
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_n = 0;
    #1 chk(snap == (a == 8'h00), "R9 snap_o", 64'(snap), 64'(a == 8'h00));
    @(negedge clk); rd_n = 1;
    #1 d = rdata;
  endtask

  task automatic clear_err();
    logic [7:0] d;
    bus_write(A_STAT, 8'h01);
    bus_read(A_STAT, d);
    chk(d[0] == 0, "R11 clear", 64'(d), 64'(0));
  endtask

  // relock with given carry stall and check the load outcome
  task automatic relock_chk(input int stall, input bit exp_ok, input logic [47:0] exp_t, input string req);
    logic [7:0] d;
    carry = (stall > 0);
    bus_write(A_KEY, 8'h00);
    for (int k = 0; k < stall; k++) begin
      #1 chk(commit == 0, "R6 deferred", 64'(commit), 64'(0));
      @(negedge clk);
    end
    carry = 0;
    #1 chk(commit == exp_ok, {req, " commit_o"}, 64'(commit), 64'(exp_ok));
    if (exp_ok) chk(ctime == exp_t, {req, " commit_time_o"}, 64'(ctime), 64'(exp_t));
    @(negedge clk);
    #1 chk(commit == 0, "R5 one cycle", 64'(commit), 64'(0));
    bus_read(A_STAT, d);
    chk(d[0] == !exp_ok, {req, " R7 error bit"}, 64'(d[0]), 64'(!exp_ok));
    chk(d[1] == 0, "R2 relocked", 64'(d[1]), 64'(0));
    if (!exp_ok) clear_err();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [47:0] t1, t2, sh, mg;
    void'($urandom(32'd1234));
    #(CLK_P*2 + 2);
    // R1
    chk(unlock == 0 && err_irq == 0 && commit == 0 && snap == 0, "R1 reset outputs",
        64'({unlock, err_irq, commit, snap}), 64'(0));
    chk(rdata == 0, "R1 rdata", 64'(rdata), 64'(0));
    @(negedge clk); rst_n = 1;

    // R2
    bus_write(A_KEY, 8'h5A);
    #1 chk(unlock == 0, "R2 wrong key", 64'(unlock), 64'(0));
    bus_write(A_KEY, KEY);
    #1 chk(unlock == 1, "R2 unlock", 64'(unlock), 64'(1));
    bus_read(A_STAT, d);
    chk(d == 8'h02, "R10 status", 64'(d), 64'(8'h02));
    cur = mk(23, 6, 15, 10, 20, 30);
    relock_chk(0, 1, cur, "R4 empty commit");

    // R3: protected write flagged and discarded
    bus_write(8'h02, 8'h05);
    #1 chk(err_irq == 1, "R3 error", 64'(err_irq), 64'(1));
    bus_write(A_STAT, 8'h00);
    #1 chk(err_irq == 1, "R11 zero keeps", 64'(err_irq), 64'(1));
    clear_err();
    bus_write(A_KEY, KEY);
    relock_chk(0, 1, cur, "R3 discarded");

    // R8 leap handling
    bus_write(A_KEY, KEY);
    bus_write(8'h03, 8'h29); bus_write(8'h04, 8'h02); bus_write(8'h05, 8'h24);
    relock_chk(1, 1, {8'h24, 8'h02, 8'h29, cur[23:0]}, "R8 leap 24");
    bus_write(A_KEY, KEY);
    bus_write(8'h03, 8'h29); bus_write(8'h04, 8'h02); bus_write(8'h05, 8'h23);
    relock_chk(0, 0, 48'h0, "R8 non-leap 23");
    bus_write(A_KEY, KEY);
    bus_write(8'h03, 8'h29); bus_write(8'h04, 8'h02); bus_write(8'h05, 8'h00);
    relock_chk(0, 1, {8'h00, 8'h02, 8'h29, cur[23:0]}, "R8 leap 00");
    bus_write(A_KEY, KEY);
    bus_write(8'h00, 8'h1A);
    relock_chk(0, 0, 48'h0, "R7 bad digit");
    bus_write(A_KEY, KEY);
    bus_write(8'h02, 8'h24);
    relock_chk(2, 0, 48'h0, "R7 hour 24");

    // R11 set wins over clear: illegal load fires with status clear
    bus_write(A_KEY, KEY);
    bus_write(8'h04, 8'h13);
    carry = 1;
    bus_write(A_KEY, 8'h00);
    @(negedge clk); addr = A_STAT; wdata = 8'h01; wr_n = 0; carry = 0;
    @(negedge clk); wr_n = 1;
    #1 chk(err_irq == 1, "R11 set wins", 64'(err_irq), 64'(1));
    clear_err();

    // R9 snapshot coherence
    t1 = gen_time(); t2 = gen_time();
    cur = t1;
    bus_read(8'h00, d);
    chk(d == t1[7:0], "R9 second", 64'(d), 64'(t1[7:0]));
    cur = t2;
    for (int i = 1; i < 6; i++) begin
      bus_read(8'(i), d);
      chk(d == t1[i*8 +: 8], "R9 cached field", 64'(d), 64'(t1[i*8 +: 8]));
    end
    bus_read(8'h00, d);
    chk(d == t2[7:0], "R9 new snapshot", 64'(d), 64'(t2[7:0]));
    bus_read(8'h07, d);
    chk(d == 0, "R10 unmapped", 64'(d), 64'(0));

    // random rounds
    for (int it = 0; it < 40; it++) begin
      t1 = gen_time(); t2 = gen_time();
      cur = t1; sh = '1;
      bus_write(A_KEY, KEY);
      for (int i = 0; i < 6; i++) begin
        if ($urandom % 2) begin
          d = ($urandom % 6 == 0) ? 8'($urandom) : t2[i*8 +: 8];
          bus_write(8'(i), d);
          sh[i*8 +: 8] = d;
        end
      end
      for (int i = 0; i < 6; i++)
        mg[i*8 +: 8] = (sh[i*8 +: 8] == 8'hFF) ? cur[i*8 +: 8] : sh[i*8 +: 8];
      relock_chk(int'($urandom % 3), tb_legal(mg), mg, "R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule